// File: doc/BRIEF.md
# Lockable System Configuration Register

This block holds one 32-bit configuration word for a system interface and a small bank of companion chip-select words, all reached over a simple internal register bus. The configuration word carries control bits for timer freeze behaviour, checkstop reset, burst pin style, an access privilege code, a debug lock, a register lock and the bus show-cycle mode. Its low half returns build-time identification constants. The decoded control fields leave the block as plain outputs for the logic that uses them. Timers, reset sequencing, the burst pin and the show-cycle logic are not part of this block.

Protection has two layers. The first is a 2-bit privilege code, which decides whether user-mode reads and writes are honoured. The second is a pair of locks. The register lock freezes the whole word and the chip-select bank. Software can only set it, except while the external freeze input is high. The debug lock can change only while frozen, and it alone decides whether the show-cycle mode can be rewritten.

A request is presented for one cycle with `req_valid`. The read data and the error flag are registered and appear in the cycle after the request. Bit positions below use index 31 as the most significant bit: freeze-stop [31], checkstop enable [28], burst-last [27], privilege code [25:24], debug lock [23], register lock [22], show mode [17:16], part id [15:8], mask id [7:0]. All other bits are reserved.

Top module: `sysconf_lock_reg`

## Requirements
- R1: After reset every writable configuration field is 0, every chip-select word is 0 and `bus_err` is 0.
- R2: Address 0 reads the configuration word with the field layout above. Bits [15:8] return PART_ID and bits [7:0] return MASK_ID. Reserved bits read 0 and ignore writes.
- R3: With `freeze` low, the register lock (bit 22) can be set but a write of 0 does not clear it. With `freeze` high, a write sets or clears it.
- R4: The debug lock (bit 23) takes the written value only while `freeze` is high. Otherwise it keeps its value.
- R5: While the register lock is 1 and `freeze` is low, a write to a chip-select word changes nothing and raises `bus_err`. A write to the configuration word leaves every field except the show mode unchanged. If the debug lock is also 1, that write raises `bus_err`.
- R6: The show mode (bits 17:16) is writable exactly when the debug lock is 0, whatever the register lock or `freeze`.
- R7: A write carrying show mode 2'b10 leaves the show mode at its previous value. The codes are 00 off, 01 write cycles, 11 all cycles.
- R8: A configuration write that the register lock blocks while the debug lock is 0 updates only the show mode and raises no error.
- R9: Privilege code 00 allows all accesses. Codes 01 and 11 allow only supervisor accesses (`req_super`=1). Code 10 allows user reads but only supervisor writes.
- R10: An access refused by the privilege code changes no state, returns read data 0, and asserts `bus_err` for exactly the one cycle after the request. Accepted reads return data in that same cycle.
- R11: Addresses above N_CS are unmapped. Such an access reads 0, writes nothing and raises `bus_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freeze | input | 1 | Debug freeze indication |
| req_valid | input | 1 | Bus request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_super | input | 1 | 1 = supervisor access, 0 = user access |
| req_addr | input | ADDR_W | 0 = configuration word, 1..N_CS = chip-select words |
| wr_data | input | 32 | Full-word write data |
| rd_data | output | 32 | Registered read data |
| bus_err | output | 1 | Registered data-error pulse |
| frz_stop | output | 1 | Stop timers during freeze |
| ckstop_rst_en | output | 1 | Reset on checkstop enable |
| burst_last | output | 1 | Burst pin uses last-beat style |
| priv_code | output | 2 | Access privilege code |
| dbg_lock | output | 1 | Debug lock state |
| reg_lock | output | 1 | Register lock state |
| show_mode | output | 2 | Bus show-cycle mode |
| cs_regs | output | 32*N_CS | Chip-select words, word i at [32*i +: 32] |

## Verification
Two functions can act in one cycle. A single configuration write can be blocked by the register lock and, at the same time, update the show mode. The outcome then depends on the debug lock: either a silent show-only update or an error with no change. The bench provokes this with an exhaustive sweep over freeze, both locks and all four show codes. Before each sweep point it programs the locks under freeze. It then judges each written word, the read-back image, the field outputs and the error pulse against a model kept in the bench. A second sweep crosses every privilege code with user and supervisor reads and writes.

// File: rtl/sysconf_pkg.sv
package sysconf_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ID_W   = 8;

  localparam int unsigned B_FRZ    = 31;
  localparam int unsigned B_CKS    = 28;
  localparam int unsigned B_BST    = 27;
  localparam int unsigned B_PRV_HI = 25;
  localparam int unsigned B_PRV_LO = 24;
  localparam int unsigned B_DLK    = 23;
  localparam int unsigned B_RLK    = 22;
  localparam int unsigned B_SHW_HI = 17;
  localparam int unsigned B_SHW_LO = 16;

  typedef struct packed {
    logic       frz_stop;
    logic       ckstop_en;
    logic       burst_last;
    logic [1:0] priv;
    logic       dlock;
    logic       rlock;
    logic [1:0] show;
  } cfg_t;

  function automatic cfg_t unpack_cfg(logic [WORD_W-1:0] w);
    cfg_t c;
    c.frz_stop   = w[B_FRZ];
    c.ckstop_en  = w[B_CKS];
    c.burst_last = w[B_BST];
    c.priv       = w[B_PRV_HI:B_PRV_LO];
    c.dlock      = w[B_DLK];
    c.rlock      = w[B_RLK];
    c.show       = w[B_SHW_HI:B_SHW_LO];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] pack_cfg(cfg_t c, logic [ID_W-1:0] part,
                                                 logic [ID_W-1:0] mask);
    logic [WORD_W-1:0] w;
    w = '0;
    w[B_FRZ]             = c.frz_stop;
    w[B_CKS]             = c.ckstop_en;
    w[B_BST]             = c.burst_last;
    w[B_PRV_HI:B_PRV_LO] = c.priv;
    w[B_DLK]             = c.dlock;
    w[B_RLK]             = c.rlock;
    w[B_SHW_HI:B_SHW_LO] = c.show;
    w[2*ID_W-1:ID_W]     = part;
    w[ID_W-1:0]          = mask;
    return w;
  endfunction

  function automatic logic access_ok(logic [1:0] code, logic sup, logic wr);
    return sup || (code == 2'b00) || (code == 2'b10 && !wr);
  endfunction

  function automatic logic show_legal(logic [1:0] v);
    return v != 2'b10;
  endfunction
endpackage

// File: rtl/sysconf_access_gate.sv
module sysconf_access_gate
  import sysconf_pkg::*;
#(
  parameter int unsigned N_CS   = 4,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_super,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        priv,
  output logic              cfg_wr,
  output logic [N_CS-1:0]   cs_wr,
  output logic              rd_en,
  output logic              priv_fault,
  output logic              addr_fault
);
  logic            mapped;
  logic            perm;
  logic            accept;
  logic [N_CS-1:0] cs_hit;

  assign mapped = int'(req_addr) <= int'(N_CS);
  assign perm   = access_ok(priv, req_super, req_write);
  assign accept = req_valid && mapped && perm;

  assign priv_fault = req_valid && mapped && !perm;
  assign addr_fault = req_valid && !mapped;
  assign cfg_wr     = accept && req_write && (req_addr == '0);
  assign rd_en      = accept && !req_write;

  for (genvar i = 0; i < int'(N_CS); i++) begin : g_dec
    assign cs_hit[i] = req_addr == ADDR_W'(i + 1);
    assign cs_wr[i]  = accept && req_write && cs_hit[i];
  end
endmodule

// File: rtl/sysconf_core_reg.sv
module sysconf_core_reg
  import sysconf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic freeze,
  input  logic wr_en,
  input  cfg_t wr_fields,
  output cfg_t cfg,
  output logic lock_active,
  output logic lock_fault
);
  cfg_t nxt;
  logic main_wr_ok;
  logic show_wr_ok;

  assign lock_active = cfg.rlock && !freeze;
  assign main_wr_ok  = wr_en && !lock_active;
  assign show_wr_ok  = wr_en && !cfg.dlock && show_legal(wr_fields.show);
  assign lock_fault  = wr_en && lock_active && cfg.dlock;

  always_comb begin
    nxt = cfg;
    if (main_wr_ok) begin
      nxt.frz_stop   = wr_fields.frz_stop;
      nxt.ckstop_en  = wr_fields.ckstop_en;
      nxt.burst_last = wr_fields.burst_last;
      nxt.priv       = wr_fields.priv;
      nxt.rlock      = freeze ? wr_fields.rlock : (cfg.rlock | wr_fields.rlock);
      if (freeze) nxt.dlock = wr_fields.dlock;
    end
    if (show_wr_ok) nxt.show = wr_fields.show;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= '0;
    else        cfg <= nxt;
  end

  p_rlock_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.rlock && !freeze) |=> cfg.rlock);

  p_dlock_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze |=> cfg.dlock == $past(cfg.dlock));

  p_locked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lock_active) |=> (cfg.priv == $past(cfg.priv) &&
                               cfg.frz_stop == $past(cfg.frz_stop) &&
                               cfg.ckstop_en == $past(cfg.ckstop_en) &&
                               cfg.burst_last == $past(cfg.burst_last)));

  p_show_dlock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.dlock |=> cfg.show == $past(cfg.show));

  p_show_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_fields.show == 2'b10) |=> cfg.show == $past(cfg.show));
endmodule

// File: rtl/sysconf_cs_bank.sv
module sysconf_cs_bank
  import sysconf_pkg::*;
#(
  parameter int unsigned N_CS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CS-1:0]          wr_en,
  input  logic                     lock_active,
  input  logic [WORD_W-1:0]        wr_data,
  output logic [WORD_W*N_CS-1:0]   cs_flat,
  output logic                     lock_fault
);
  assign lock_fault = (|wr_en) && lock_active;

  for (genvar i = 0; i < int'(N_CS); i++) begin : g_cs
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         q <= '0;
      else if (wr_en[i] && !lock_active)  q <= wr_data;
    end
    assign cs_flat[WORD_W*i +: WORD_W] = q;
  end

  p_cs_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_active |=> cs_flat == $past(cs_flat));
endmodule

// File: rtl/sysconf_lock_reg.sv
module sysconf_lock_reg
  import sysconf_pkg::*;
#(
  parameter int unsigned N_CS    = 4,
  parameter logic [7:0]  PART_ID = 8'h5A,
  parameter logic [7:0]  MASK_ID = 8'h03,
  localparam int unsigned ADDR_W = $clog2(N_CS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   freeze,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic                   req_super,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [31:0]            wr_data,
  output logic [31:0]            rd_data,
  output logic                   bus_err,
  output logic                   frz_stop,
  output logic                   ckstop_rst_en,
  output logic                   burst_last,
  output logic [1:0]             priv_code,
  output logic                   dbg_lock,
  output logic                   reg_lock,
  output logic [1:0]             show_mode,
  output logic [32*N_CS-1:0]     cs_regs
);
  cfg_t            cfg;
  logic            cfg_wr;
  logic [N_CS-1:0] cs_wr;
  logic            rd_en;
  logic            priv_fault;
  logic            addr_fault;
  logic            lock_active;
  logic            cfg_lock_fault;
  logic            cs_lock_fault;
  logic            any_err;
  logic [31:0]     rd_word;

  sysconf_access_gate #(.N_CS(N_CS), .ADDR_W(ADDR_W)) u_gate (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_super (req_super),
    .req_addr  (req_addr),
    .priv      (cfg.priv),
    .cfg_wr    (cfg_wr),
    .cs_wr     (cs_wr),
    .rd_en     (rd_en),
    .priv_fault(priv_fault),
    .addr_fault(addr_fault)
  );

  sysconf_core_reg u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .freeze     (freeze),
    .wr_en      (cfg_wr),
    .wr_fields  (unpack_cfg(wr_data)),
    .cfg        (cfg),
    .lock_active(lock_active),
    .lock_fault (cfg_lock_fault)
  );

  sysconf_cs_bank #(.N_CS(N_CS)) u_cs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cs_wr),
    .lock_active(lock_active),
    .wr_data    (wr_data),
    .cs_flat    (cs_regs),
    .lock_fault (cs_lock_fault)
  );

  assign any_err = priv_fault || addr_fault || cfg_lock_fault || cs_lock_fault;

  always_comb begin
    rd_word = '0;
    if (req_addr == '0) rd_word = pack_cfg(cfg, PART_ID, MASK_ID);
    for (int i = 0; i < int'(N_CS); i++) begin
      if (req_addr == ADDR_W'(i + 1)) rd_word = cs_regs[32*i +: 32];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      bus_err <= 1'b0;
    end else begin
      rd_data <= rd_en ? rd_word : '0;
      bus_err <= any_err;
    end
  end

  assign frz_stop      = cfg.frz_stop;
  assign ckstop_rst_en = cfg.ckstop_en;
  assign burst_last    = cfg.burst_last;
  assign priv_code     = cfg.priv;
  assign dbg_lock      = cfg.dlock;
  assign reg_lock      = cfg.rlock;
  assign show_mode     = cfg.show;

  p_show_only_noerr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && lock_active && !cfg.dlock) |=> !bus_err);

  p_err_follows_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(req_valid));

  p_fault_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && priv_fault) |=> (bus_err && rd_data == '0));

  p_unmapped_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && addr_fault) |=> (bus_err && rd_data == '0));
endmodule

// File: tb/sysconf_lock_reg_tb.sv
module sysconf_lock_reg_tb;
  localparam int unsigned N_CS = 4;
  localparam logic [7:0] PART = 8'h5A;
  localparam logic [7:0] MASK = 8'h03;
  localparam int unsigned AW = $clog2(N_CS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic freeze = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic req_super = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic bus_err, frz_stop, ckstop_rst_en, burst_last, dbg_lock, reg_lock;
  logic [1:0] priv_code, show_mode;
  logic [32*N_CS-1:0] cs_regs;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] m_cfg;
  logic [31:0] m_cs [N_CS];

  always #5 clk = ~clk;

  sysconf_lock_reg #(.N_CS(N_CS), .PART_ID(PART), .MASK_ID(MASK)) u_dut (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .req_valid(req_valid),
    .req_write(req_write), .req_super(req_super), .req_addr(req_addr),
    .wr_data(wr_data), .rd_data(rd_data), .bus_err(bus_err),
    .frz_stop(frz_stop), .ckstop_rst_en(ckstop_rst_en), .burst_last(burst_last),
    .priv_code(priv_code), .dbg_lock(dbg_lock), .reg_lock(reg_lock),
    .show_mode(show_mode), .cs_regs(cs_regs)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] port_image();
    return {frz_stop, 2'b00, ckstop_rst_en, burst_last, 1'b0, priv_code,
            dbg_lock, reg_lock, 4'b0000, show_mode, PART, MASK};
  endfunction

  function automatic logic [31:0] cfg_model(logic [31:0] cur, logic [31:0] wd,
                                            logic frz, output logic err);
    logic [31:0] n;
    logic blocked;
    blocked = cur[22] && !frz;
    n = cur;
    err = blocked && cur[23];
    if (!blocked) begin
      n[31] = wd[31]; n[28] = wd[28]; n[27] = wd[27];
      n[25:24] = wd[25:24];
      n[22] = wd[22];
      if (frz) n[23] = wd[23];
    end
    if (!cur[23] && wd[17:16] != 2'b10) n[17:16] = wd[17:16];
    return n;
  endfunction

  task automatic access(string tag, logic wr, logic sup, int addr,
                        logic [31:0] data, logic frz);
    logic ok, mapped, e_err;
    logic [31:0] e_rd;
    logic [1:0] code;
    code = m_cfg[25:24];
    ok = sup || code == 2'b00 || (code == 2'b10 && !wr);
    mapped = addr <= int'(N_CS);
    e_err = 1'b0;
    e_rd = '0;
    if (!mapped || !ok) e_err = 1'b1;
    else if (!wr) e_rd = (addr == 0) ? m_cfg : m_cs[addr-1];
    else if (addr == 0) m_cfg = cfg_model(m_cfg, data, frz, e_err);
    else begin
      e_err = m_cfg[22] && !frz;
      if (!e_err) m_cs[addr-1] = data;
    end
    @(negedge clk);
    freeze = frz; req_valid = 1'b1; req_write = wr; req_super = sup;
    req_addr = AW'(addr); wr_data = data;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " err"}, {31'b0, bus_err}, {31'b0, e_err});
    chk({tag, " rdata"}, rd_data, e_rd);
    chk({tag, " cfg"}, port_image(), m_cfg);
    for (int i = 0; i < int'(N_CS); i++)
      chk({tag, " cs"}, cs_regs[32*i +: 32], m_cs[i]);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    string tg;
    m_cfg = {16'h0000, PART, MASK};
    for (int i = 0; i < int'(N_CS); i++) m_cs[i] = '0;
    #12;
    // R1: reset state
    chk("R1 cfg", port_image(), m_cfg);
    chk("R1 cs", cs_regs[31:0], 32'h0);
    chk("R1 err", {31'b0, bus_err}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 err after", {31'b0, bus_err}, 32'h0);

    // R2: read image with identification constants
    access("R2", 1'b0, 1'b0, 0, 32'h0, 1'b0);
    access("R2", 1'b1, 1'b1, 0, 32'h6C3C_FFFF, 1'b1);
    access("R2", 1'b0, 1'b1, 0, 32'h0, 1'b0);
    access("R2", 1'b1, 1'b1, 0, 32'h0, 1'b1);

    // R4: debug lock refuses change outside freeze
    access("R4", 1'b1, 1'b1, 0, 32'h0080_0000, 1'b0);
    access("R4", 1'b1, 1'b1, 0, 32'h0080_0000, 1'b1);
    access("R4", 1'b1, 1'b1, 0, 32'h0000_0000, 1'b0);
    access("R4", 1'b1, 1'b1, 0, 32'h0000_0000, 1'b1);

    // R3: register lock set-only outside freeze
    access("R3", 1'b1, 1'b1, 0, 32'h0040_0000, 1'b0);
    access("R3", 1'b1, 1'b1, 0, 32'h0000_0000, 1'b0);
    access("R3", 1'b1, 1'b1, 0, 32'h0000_0000, 1'b1);

    // Sweep freeze x locks x show codes x field pattern (R5 R6 R7 R8)
    for (int fz = 0; fz < 2; fz++)
      for (int rl = 0; rl < 2; rl++)
        for (int dl = 0; dl < 2; dl++)
          for (int sv = 0; sv < 4; sv++)
            for (int p = 0; p < 2; p++) begin
              logic [31:0] w;
              access("R3 setup", 1'b1, 1'b1, 0, 32'h0000_0000, 1'b1);
              access("R4 setup", 1'b1, 1'b1, 0,
                     {8'h00, dl[0], rl[0], 22'h0} | (p[0] ? 32'h0001_0000 : 32'h0),
                     1'b1);
              w = (p[0] ? 32'h9800_0000 : 32'h0800_0000) | {14'h0, sv[1:0], 16'h0};
              if (fz == 0 && rl == 1) tg = (dl == 1) ? "R5" : "R8";
              else tg = (sv == 2) ? "R7" : "R6";
              access(tg, 1'b1, 1'b1, 0, w, fz[0]);
              access(rl == 1 && fz == 0 ? "R5" : "R6", 1'b1, 1'b1,
                     1 + (sv % int'(N_CS)), {sv[7:0], p[7:0], 16'hA5C3}, fz[0]);
              access("R7", 1'b0, 1'b1, 0, 32'h0, fz[0]);
            end

    // R9 and R10: privilege code against user/supervisor reads and writes
    for (int code = 0; code < 4; code++)
      for (int sup = 0; sup < 2; sup++)
        for (int wr = 0; wr < 2; wr++) begin
          access("R9 setup", 1'b1, 1'b1, 0, {6'h0, code[1:0], 24'h0}, 1'b1);
          access("R10", wr[0], sup[0], 2, {code[7:0], 8'h5C, sup[7:0], wr[7:0]}, 1'b0);
          access("R9", 1'b0, sup[0], 2, 32'h0, 1'b0);
        end

    // R11: unmapped addresses
    access("R9 clear", 1'b1, 1'b1, 0, 32'h0, 1'b1);
    access("R11", 1'b0, 1'b1, 5, 32'h0, 1'b0);
    access("R11", 1'b1, 1'b1, 6, 32'hFFFF_FFFF, 1'b0);
    access("R11", 1'b0, 1'b0, 7, 32'h0, 1'b0);

    // R10: error lasts one cycle
    @(negedge clk);
    chk("R10 pulse end", {31'b0, bus_err}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule